// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block keeps a per-processor running flag for a cluster of virtual processors and lets software start or halt them through a small register-bus slave. Writing a one-hot or multi-bit mask to the start register launches every selected processor that is currently halted. The launch emits a one-cycle reset pulse to the processor, and the processor is marked running once it returns its reset-done strobe. Writing a mask to the halt register stops every selected processor that is marked running. The halt emits a one-cycle halt pulse and clears the flag at once.

The three registers are decoded at identical offsets inside two separate address windows, and the two windows behave the same way. Software reads the running flags back through a status register. The processor count and a power-on launch mask are parameters. After reset every flag is clear, and each processor named in the launch mask is sent through the normal launch sequence on its own.

Top module: `vprc_top`

## Requirements
- R1: While reset is held every running flag is clear and no pulse is driven. In the first cycle after reset is released, a reset pulse is driven for exactly the processors set in START_MASK.
- R2: A write to the start register (window offset 0x00) drives a reset pulse, in the cycle after the write is accepted, to each selected processor that is halted. Its running flag stays clear until R4 sets it.
- R3: Every reset pulse lasts exactly one cycle.
- R4: A processor waiting after a reset pulse becomes running in the cycle after its reset-done input is sampled high. Reset-done on a processor that is not waiting has no effect.
- R5: A start request for a processor that is running or waiting is ignored: it produces no pulse and no change of flag.
- R6: A write to the halt register (window offset 0x08) gives each selected running processor a one-cycle halt pulse and clears its flag, both in the cycle after the write is accepted. A selected processor that is not running is ignored.
- R7: Write-data bits at and above NUM_VP have no effect on either command.
- R8: A read of the status register (window offset 0x10) returns the running flags, zero-extended to 64 bits, in the cycle after rd_en. In a cycle with no read, rdata is zero.
- R9: Window 1 (addr[15:13]=1) and window 2 (addr[15:13]=2) decode the same offsets and act identically.
- R10: A read of any other address returns zero, and a write to any other address changes nothing.
- R11: A START_MASK with bits at or above NUM_VP, or a NUM_VP outside 1..64, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 64 | Read data, registered |
| vp_rst_req | output | NUM_VP | One-cycle reset pulse per processor |
| vp_halt_req | output | NUM_VP | One-cycle halt pulse per processor |
| vp_rst_done | input | NUM_VP | Reset-complete strobe per processor |

## Verification
The bench builds the block with NUM_VP=5 and START_MASK=0x09. With that setting the power-on launch covers a mixed pattern, with some processors launching and some staying halted. Write data that sets bits 5 to 63 then checks that the mask discards them. With five processors a single command can hit a running, a waiting and a halted processor together, so the ignore rules for each state are checked against one another. Both windows are used for the same commands, and reads and writes go to an empty window and an empty offset.

// File: rtl/vprc_pkg.sv
package vprc_pkg;
   // register selected by an access
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RUN  = 2'd1,
      SEL_STOP = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   // per-processor lifecycle
   typedef enum logic [1:0] {
      ST_HALT = 2'd0,
      ST_BOOT = 2'd1,
      ST_WAIT = 2'd2,
      ST_RUN  = 2'd3
   } vp_state_e;

   // byte offsets inside a window
   localparam int OFS_RUN  = 'h00;
   localparam int OFS_STOP = 'h08;
   localparam int OFS_STAT = 'h10;
endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
   import vprc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_SHIFT = 13,
   parameter int WIN0_IDX  = 1,
   parameter int WIN1_IDX  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam int PAGE_W  = ADDR_W - WIN_SHIFT;
   localparam int NUM_WIN = 2;
   localparam logic [NUM_WIN-1:0][PAGE_W-1:0] WIN_IDX =
      {PAGE_W'(WIN1_IDX), PAGE_W'(WIN0_IDX)};

   logic [NUM_WIN-1:0]    win_hit;
   logic [WIN_SHIFT-1:0]  ofs;

   assign ofs = addr[WIN_SHIFT-1:0];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      assign win_hit[w] = (addr[ADDR_W-1:WIN_SHIFT] == WIN_IDX[w]);
   end

   always_comb begin
      sel = SEL_NONE;
      if (|win_hit) begin
         if (ofs == WIN_SHIFT'(OFS_RUN))       sel = SEL_RUN;
         else if (ofs == WIN_SHIFT'(OFS_STOP)) sel = SEL_STOP;
         else if (ofs == WIN_SHIFT'(OFS_STAT)) sel = SEL_STAT;
      end
   end
endmodule

// File: rtl/vprc_lane.sv
module vprc_lane
   import vprc_pkg::*;
#(
   parameter bit LAUNCH_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_cmd,
   input  logic stop_cmd,
   input  logic rst_done,
   output logic rst_req,
   output logic halt_req,
   output logic running
);
   vp_state_e st_q;
   logic      rst_req_q;
   logic      halt_req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= LAUNCH_AT_RESET ? ST_BOOT : ST_HALT;
         rst_req_q  <= 1'b0;
         halt_req_q <= 1'b0;
      end else begin
         rst_req_q  <= 1'b0;
         halt_req_q <= 1'b0;
         unique case (st_q)
            ST_HALT: if (run_cmd) begin
               st_q      <= ST_WAIT;
               rst_req_q <= 1'b1;
            end
            ST_BOOT: begin
               st_q      <= ST_WAIT;
               rst_req_q <= 1'b1;
            end
            ST_WAIT: if (rst_done) st_q <= ST_RUN;
            ST_RUN: if (stop_cmd) begin
               st_q       <= ST_HALT;
               halt_req_q <= 1'b1;
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end

   assign rst_req  = rst_req_q;
   assign halt_req = halt_req_q;
   assign running  = (st_q == ST_RUN);
endmodule

// File: rtl/vprc_top.sv
module vprc_top
   import vprc_pkg::*;
#(
   parameter int          NUM_VP     = 1,
   parameter logic [63:0] START_MASK = 64'h1,
   parameter int          ADDR_W     = 16,
   parameter int          WIN_SHIFT  = 13,
   parameter int          WIN0_IDX   = 1,
   parameter int          WIN1_IDX   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [63:0]       rdata,
   output logic [NUM_VP-1:0] vp_rst_req,
   output logic [NUM_VP-1:0] vp_halt_req,
   input  logic [NUM_VP-1:0] vp_rst_done
);
   localparam int          DATA_W   = 64;
   localparam logic [63:0] OUT_BITS = ~((64'd1 << NUM_VP) - 64'd1);
   localparam logic [NUM_VP-1:0] VALID = '1;

   // elaboration-time parameter checks (R11)
   if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
      $error("vprc_top: NUM_VP must lie in 1..64");
   end
   if ((START_MASK & OUT_BITS) != 64'd0) begin : g_bad_start
      $error("vprc_top: START_MASK selects processors beyond NUM_VP");
   end
   if (ADDR_W <= WIN_SHIFT || WIN_SHIFT < 5) begin : g_bad_addr
      $error("vprc_top: address split leaves no room for windows or offsets");
   end

   reg_sel_e          sel;
   logic [NUM_VP-1:0] run_cmd;
   logic [NUM_VP-1:0] stop_cmd;
   logic [NUM_VP-1:0] run_vec;
   logic [63:0]       rdata_q;

   vprc_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_SHIFT(WIN_SHIFT),
      .WIN0_IDX (WIN0_IDX),
      .WIN1_IDX (WIN1_IDX)
   ) i_decode (
      .addr(addr),
      .sel (sel)
   );

   assign run_cmd  = (wr_en && sel == SEL_RUN)  ? (wdata[NUM_VP-1:0] & VALID) : '0;
   assign stop_cmd = (wr_en && sel == SEL_STOP) ? (wdata[NUM_VP-1:0] & VALID) : '0;

   for (genvar g = 0; g < NUM_VP; g++) begin : g_lane
      vprc_lane #(
         .LAUNCH_AT_RESET(START_MASK[g])
      ) i_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .run_cmd (run_cmd[g]),
         .stop_cmd(stop_cmd[g]),
         .rst_done(vp_rst_done[g]),
         .rst_req (vp_rst_req[g]),
         .halt_req(vp_halt_req[g]),
         .running (run_vec[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= (rd_en && sel == SEL_STAT) ? DATA_W'(run_vec) : '0;
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/vprc_checker.sv
module vprc_checker #(
   parameter int NUM_VP = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [63:0]       rdata,
   input logic [NUM_VP-1:0] vp_rst_req,
   input logic [NUM_VP-1:0] vp_halt_req,
   input logic [NUM_VP-1:0] vp_rst_done,
   input logic [NUM_VP-1:0] running
);
   // R3: a reset pulse never lasts two cycles
   a_r3_rst_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      (vp_rst_req != '0) |=> ((vp_rst_req & $past(vp_rst_req)) == '0));

   // R6: a halt pulse never lasts two cycles
   a_r6_halt_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      (vp_halt_req != '0) |=> ((vp_halt_req & $past(vp_halt_req)) == '0));

   // R6: a halt pulse goes only to a processor that was running and is now cleared
   a_r6_halt_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((vp_halt_req & running) == '0) &&
      ((vp_halt_req & ~$past(running)) == '0));

   // R4: a flag rises only after reset-done was sampled
   a_r4_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      ((running & ~$past(running) & ~$past(vp_rst_done)) == '0));

   // R2: a reset pulse never goes to a processor that is already running
   a_r2_pulse_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
      ((vp_rst_req & running) == '0));

   // R8: no read, no data
   a_r8_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == 64'd0));
endmodule

bind vprc_top vprc_checker #(
   .NUM_VP(NUM_VP)
) i_vprc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .rdata      (rdata),
   .vp_rst_req (vp_rst_req),
   .vp_halt_req(vp_halt_req),
   .vp_rst_done(vp_rst_done),
   .running    (run_vec)
);

// File: tb/test_vprc_top.sv
module test_vprc_top;
   localparam int          NV    = 5;
   localparam logic [63:0] SMASK = 64'h09;
   localparam logic [15:0] WA    = 16'h2000;
   localparam logic [15:0] WB    = 16'h4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   addr = '0;
   logic [63:0]   wdata = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [63:0]   rdata;
   logic [NV-1:0] vp_rst_req;
   logic [NV-1:0] vp_halt_req;
   logic [NV-1:0] vp_rst_done = '0;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [63:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t exp_q[$];
   logic     rd_seen = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   vprc_top #(.NUM_VP(NV), .START_MASK(SMASK)) i_vprc_top (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
      .vp_rst_req(vp_rst_req), .vp_halt_req(vp_halt_req),
      .vp_rst_done(vp_rst_done)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: a read issued at the last edge is compared against the queue head
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R8: read response with no expectation, got %h expected none", rdata);
         end else begin
            rd_item_t it;
            it = exp_q.pop_front();
            check(rdata, it.exp, it.tag);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back('{exp, tag});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic done_pulse(input logic [NV-1:0] v);
      @(negedge clk);
      vp_rst_done = v;
      @(negedge clk);
      vp_rst_done = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(vp_rst_req, '0, "R1 no reset pulse in reset");
      check(rdata, '0, "R1 rdata in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(vp_rst_req, SMASK[NV-1:0], "R1 power-on launch pulse");
      @(negedge clk);
      check(vp_rst_req, '0, "R3 launch pulse one cycle");
      rd(WA + 16'h10, 64'h0, "R4 waiting not yet running");
      done_pulse(5'h1F);                         // bits 1,2,4 not waiting: ignored
      rd(WA + 16'h10, 64'h09, "R4 running after done");

      wr(WA, 64'hFFFF_FFFF_FFFF_FFE3);           // bit0 running, bit1 halted, high bits masked
      check(vp_rst_req, 5'h02, "R2 R5 R7 start pulse selection");
      @(negedge clk);
      check(vp_rst_req, '0, "R3 start pulse one cycle");
      rd(WA + 16'h10, 64'h09, "R2 flag waits for done");
      wr(WA, 64'h02);                            // already waiting
      check(vp_rst_req, '0, "R5 repeat start while waiting");
      done_pulse(5'h02);
      rd(WA + 16'h10, 64'h0B, "R4 second launch completes");

      wr(WB + 16'h08, 64'h0C);                   // bit3 running, bit2 halted
      check(vp_halt_req, 5'h08, "R6 R9 halt pulse via window 2");
      @(negedge clk);
      check(vp_halt_req, '0, "R6 halt pulse one cycle");
      rd(WB + 16'h10, 64'h03, "R6 R9 status via window 2");

      wr(WA + 16'h08, 64'hFFFF_FFFF_FFFF_FFE0);
      check(vp_halt_req, '0, "R7 high stop bits ignored");
      rd(WA + 16'h10, 64'h03, "R7 flags unchanged");

      wr(WA + 16'h18, '1);
      check(vp_rst_req | vp_halt_req, '0, "R10 write to empty offset");
      wr(16'h0000, '1);
      check(vp_rst_req | vp_halt_req, '0, "R10 write outside windows");
      wr(16'h6008, '1);
      check(vp_rst_req | vp_halt_req, '0, "R10 write to empty window");
      rd(WA + 16'h10, 64'h03, "R10 flags unchanged after stray writes");
      rd(WA + 16'h18, 64'h0, "R10 read empty offset");
      rd(16'h6010, 64'h0, "R10 read empty window");
      @(negedge clk);
      check(rdata, '0, "R8 rdata zero without read");

      wr(WB, 64'h04);
      check(vp_rst_req, 5'h04, "R9 start via window 2");
      done_pulse(5'h04);
      rd(WA + 16'h10, 64'h07, "R9 R8 status after window-2 start");
      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL R8: %0d read responses missing, expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule